// File: doc/BRIEF.md
# Programmable-Length CRC Engine with Word Queue

This block computes a cyclic redundancy check of programmable width (1 to 16 bits) over a stream of data words. Software writes words into a small queue in front of a bit-serial linear feedback shift register. Once a start control is set, the engine takes the oldest queued word and feeds its bits, most significant first, into the register at one bit per clock. A queued word is retired after its last bit has been shifted.

The element width and the top stage of the register both come from a 4-bit length field. A 16-bit tap register picks which stages receive the feedback XOR. The queue holds 16 words for narrow elements and 8 words for wide ones. Status outputs give the number of queued words, full and empty flags, and an interrupt pulse when the queue drains through shifting. A sleep input, or an idle input combined with an idle-stop control, freezes the block in place. A synchronous clear restarts the computation.

Top module: `crc_fifo_engine`

## Requirements
- R1: The element width is `cfg_len`+1 bits. Bits [`cfg_len`:0] of each written word are used, starting at bit `cfg_len`. `crc_out` shows only bits [`cfg_len`:0] of the register, and all higher bits read 0.
- R2: The queue depth is 8 when `cfg_len` > 7 and 16 otherwise. `full` is 1 exactly when `cnt` equals the depth, and `empty` is 1 exactly when `cnt` is 0.
- R3: An accepted write raises `cnt` by one. Retiring a word lowers `cnt` by one. A write and a retire in the same cycle leave `cnt` unchanged. `cnt` never exceeds 16.
- R4: One bit is shifted per cycle, and only while `go` is 1 and `cnt` is nonzero. Each word takes exactly `cfg_len`+1 shifting cycles before it retires. While `go` is 0, the register and `cnt` hold.
- R5: On each shift, let fb = register bit `cfg_len` XOR the data bit. The register then shifts up by one with a 0 entering stage 0, each stage i whose `cfg_taps[i]` is 1 is XORed with fb, and the result is masked to `cfg_len`+1 bits.
- R6: A write while `cnt` equals the depth discards all queued words. `cnt` becomes 0, no shift happens in that cycle, and `irq` stays 0.
- R7: `irq` is high for exactly one cycle. That cycle is the one in which `cnt` first reads 0 after a retire took it from 1 to 0.
- R8: While `sleep` is 1, or `idle` and `idle_stop` are both 1, all state holds and writes are ignored. When `idle` is 1 and `idle_stop` is 0, operation continues normally.
- R9: `sync_clr` zeroes the register, `cnt`, the queue pointers and the in-word bit position. This takes effect even while the block is frozen.
- R10: After reset, `cnt` is 0, `empty` is 1, `full` is 0, `irq` is 0 and `crc_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_clr | input | 1 | Synchronous clear of register, queue and bit position |
| cfg_len | input | 4 | Element width minus one; also selects the top register stage |
| cfg_taps | input | 16 | Feedback enable per register stage |
| wr_en | input | 1 | Push `wr_data` into the queue |
| wr_data | input | 16 | Data word |
| go | input | 1 | Enables shifting |
| sleep | input | 1 | Freeze the block |
| idle | input | 1 | Idle request |
| idle_stop | input | 1 | Freeze while idle |
| cnt | output | 5 | Number of queued words |
| full | output | 1 | Queue at depth |
| empty | output | 1 | Queue empty |
| irq | output | 1 | One-cycle pulse when the queue drains by shifting |
| crc_out | output | 16 | Register contents masked to the element width |

## Verification
The bench checks the exact completion cycle of each run. An engine that retires a word one cycle early or late would show `cnt` and `irq` at the wrong time. It writes one word past full and confirms that the count drops to zero with no interrupt, and that later words start from an empty queue; a wrap that fell through to an increment, or that pulsed `irq`, is reported. Runs are interrupted by sleep, by idle with and without the stop control, and by dropping `go`. A design that leaked a shift, or accepted a write, while frozen gives a different checksum or count. Lengths 7 and 8 check the depth switch, a write placed on a word's last bit checks the simultaneous push and retire, and a clear issued in the middle of a word checks that the bit position restarts.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int unsigned CRC_W   = 16;
  localparam int unsigned LEN_W   = $clog2(CRC_W);
  localparam int unsigned DEEP    = 16;
  localparam int unsigned SHALLOW = 8;
  localparam int unsigned SPLIT   = 7;
  localparam int unsigned PTR_W   = $clog2(DEEP);
  localparam int unsigned CNT_W   = PTR_W + 1;

  typedef logic [CRC_W-1:0] crc_t;
  typedef logic [LEN_W-1:0] len_t;
  typedef logic [PTR_W-1:0] ptr_t;
  typedef logic [CNT_W-1:0] cnt_t;

  function automatic logic is_shallow(len_t len);
    return int'(len) > SPLIT;
  endfunction

  function automatic cnt_t depth_of(len_t len);
    return is_shallow(len) ? cnt_t'(SHALLOW) : cnt_t'(DEEP);
  endfunction

  function automatic crc_t len_mask(len_t len);
    crc_t m;
    for (int i = 0; i < CRC_W; i++) m[i] = (i <= int'(len));
    return m;
  endfunction

  function automatic crc_t lfsr_next(crc_t cur, crc_t taps, len_t len, logic din);
    logic fb;
    crc_t nx;
    fb = cur[len] ^ din;
    nx = {cur[CRC_W-2:0], 1'b0};
    if (fb) nx = nx ^ taps;
    return nx & len_mask(len);
  endfunction

  function automatic ptr_t ptr_bump(ptr_t p, logic shallow);
    ptr_t nx;
    nx = p + 1'b1;
    if (shallow && nx == ptr_t'(SHALLOW)) nx = '0;
    return nx;
  endfunction
endpackage

// File: rtl/crc_word_fifo.sv
module crc_word_fifo
  import crc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic wrap,
  input  logic push,
  input  logic pop,
  input  logic shallow,
  input  crc_t wdata,
  output crc_t head,
  output cnt_t count
);
  crc_t mem [DEEP];
  ptr_t wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr || wrap) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_bump(wr_ptr, shallow);
      if (pop)  rd_ptr <= ptr_bump(rd_ptr, shallow);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head = mem[rd_ptr];

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= cnt_t'(DEEP));
  assert_cnt_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !clr && !wrap) |=> count == $past(count) + 1'b1);
  assert_pop_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count != '0);
endmodule

// File: rtl/crc_lfsr_core.sv
module crc_lfsr_core
  import crc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  logic din,
  input  len_t len,
  input  crc_t taps,
  output crc_t crc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= '0;
    else if (clr)  crc_q <= '0;
    else if (step) crc_q <= lfsr_next(crc_q, taps, len, din);
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(crc_q));
  assert_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(step) |-> (crc_q & ~len_mask($past(len))) == '0);
endmodule

// File: rtl/crc_fifo_engine.sv
module crc_fifo_engine
  import crc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sync_clr,
  input  logic [3:0]  cfg_len,
  input  logic [15:0] cfg_taps,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic        go,
  input  logic        sleep,
  input  logic        idle,
  input  logic        idle_stop,
  output logic [4:0]  cnt,
  output logic        full,
  output logic        empty,
  output logic        irq,
  output logic [15:0] crc_out
);
  logic active, frozen, wrap, push, step, last, din;
  cnt_t depth, cnt_q;
  crc_t head, crc_q;
  len_t bit_idx;

  assign frozen = sleep || (idle && idle_stop);
  assign active = !frozen && !sync_clr;
  assign depth  = depth_of(cfg_len);
  assign wrap   = active && wr_en && (cnt_q == depth);
  assign push   = active && wr_en && !wrap;
  assign step   = active && go && (cnt_q != '0) && !wrap;
  assign last   = step && (bit_idx == cfg_len);
  assign din    = head[len_t'(cfg_len - bit_idx)];

  crc_word_fifo u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(sync_clr), .wrap(wrap),
    .push(push), .pop(last), .shallow(is_shallow(cfg_len)),
    .wdata(wr_data), .head(head), .count(cnt_q)
  );

  crc_lfsr_core u_lfsr (
    .clk(clk), .rst_n(rst_n), .clr(sync_clr), .step(step),
    .din(din), .len(cfg_len), .taps(cfg_taps), .crc_q(crc_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx <= '0;
      irq     <= 1'b0;
    end else begin
      if (sync_clr || wrap) bit_idx <= '0;
      else if (step)        bit_idx <= last ? '0 : bit_idx + 1'b1;
      irq <= last && !push && (cnt_q == cnt_t'(1));
    end
  end

  assign cnt     = cnt_q;
  assign full    = (cnt_q == depth);
  assign empty   = (cnt_q == '0);
  assign crc_out = crc_q & len_mask(cfg_len);

  assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !sync_clr) |=> ($stable(cnt_q) && $stable(crc_q) && !irq));
  assert_wrap_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0 && !irq));
  assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cnt_q == '0 && $past(cnt_q) == cnt_t'(1)));
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr |=> (cnt_q == '0 && crc_q == '0));
endmodule

// File: tb/crc_fifo_engine_tb_top.sv
module crc_fifo_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_clr = 0, wr_en = 0, go = 0, sleep = 0, idle = 0, idle_stop = 0;
  logic [3:0] cfg_len = 0;
  logic [15:0] cfg_taps = 0, wr_data = 0;
  logic [4:0] cnt;
  logic full, empty, irq;
  logic [15:0] crc_out;
  int checks = 0;
  int errors = 0;
  int unsigned seed_v;

  always #2.5 clk = ~clk;

  crc_fifo_engine dut_i (
    .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .cfg_len(cfg_len),
    .cfg_taps(cfg_taps), .wr_en(wr_en), .wr_data(wr_data), .go(go),
    .sleep(sleep), .idle(idle), .idle_stop(idle_stop), .cnt(cnt),
    .full(full), .empty(empty), .irq(irq), .crc_out(crc_out)
  );

  // Reference: one element at a time, written as mask/shift arithmetic
  function automatic logic [15:0] ref_word(logic [15:0] acc, int len,
                                           logic [15:0] taps, logic [15:0] w);
    logic [16:0] m;
    logic fb;
    m = (17'd1 << (len + 1)) - 17'd1;
    for (int i = len; i >= 0; i--) begin
      fb  = acc[len] ^ w[i];
      acc = (acc << 1) & m[15:0];
      if (fb) acc = acc ^ (taps & m[15:0]);
    end
    return acc;
  endfunction

  function automatic int depth_for(int len);
    return (len > 7) ? 8 : 16;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_clear();
    sync_clr = 1'b1;
    tick();
    sync_clr = 1'b0;
  endtask

  task automatic push_word(logic [15:0] w);
    wr_en = 1'b1;
    wr_data = w;
    tick();
    wr_en = 1'b0;
  endtask

  // mode: 0 none, 1 sleep, 2 idle+stop, 3 idle running, 4 go dropped
  task automatic run_case(int len, logic [15:0] taps, int n, int mode);
    logic [15:0] exp, w, held_crc;
    int total, p, rem, held_cnt;
    localparam int F = 5;
    cfg_len = 4'(len);
    cfg_taps = taps;
    do_clear();
    exp = '0;
    for (int k = 0; k < n; k++) begin
      w = 16'($urandom);
      exp = ref_word(exp, len, taps, w);
      push_word(w);
    end
    chk(cnt == 5'(n), "R3 count after writes", cnt, n);
    chk(full == (n == depth_for(len)), "R2 full flag", full, n == depth_for(len));
    chk(empty == 1'b0, "R2 empty flag", empty, 0);
    total = n * (len + 1);
    p = (mode == 3) ? 0 : total / 2;
    go = 1'b1;
    repeat (p) tick();
    if (mode != 0) begin
      held_cnt = cnt;
      held_crc = crc_out;
      case (mode)
        1: sleep = 1'b1;
        2: begin idle = 1'b1; idle_stop = 1'b1; end
        3: begin idle = 1'b1; idle_stop = 1'b0; end
        default: go = 1'b0;
      endcase
      repeat (F) begin
        if (mode == 1 || mode == 2) begin
          wr_en = 1'b1;
          wr_data = 16'($urandom);
        end
        tick();
      end
      wr_en = 1'b0;
      if (mode != 3) begin
        chk(cnt == 5'(held_cnt), "R8/R4 count held while paused", cnt, held_cnt);
        chk(crc_out == held_crc, "R8/R4 crc held while paused", crc_out, held_crc);
      end
      sleep = 1'b0;
      idle = 1'b0;
      idle_stop = 1'b0;
      go = 1'b1;
    end
    rem = total - p - ((mode == 3) ? F : 0);
    repeat (rem - 1) tick();
    chk(cnt == 5'd1, "R4 last word pending one cycle before end", cnt, 1);
    chk(irq == 1'b0, "R7 no early irq", irq, 0);
    tick();
    chk(cnt == 5'd0 && empty, "R4 drained on time", cnt, 0);
    chk(irq == 1'b1, "R7 irq on 1-to-0", irq, 1);
    chk(crc_out == exp, "R5 R1 crc value", crc_out, exp);
    tick();
    chk(irq == 1'b0, "R7 irq one cycle only", irq, 0);
    go = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] e, w;
    int len, bad_irq;
    seed_v = $urandom(32'h5eed_c0de);
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R10 reset state
    chk(cnt == 5'd0, "R10 reset count", cnt, 0);
    chk(empty == 1'b1 && full == 1'b0, "R10 reset flags", {empty, full}, 2);
    chk(irq == 1'b0, "R10 reset irq", irq, 0);
    chk(crc_out == 16'd0, "R10 reset crc", crc_out, 0);

    // directed: depth boundary R2 and a known polynomial
    run_case(15, 16'h1021, 4, 0);
    run_case(7, 16'h00a7, 16, 0);
    run_case(7, 16'h0013, 8, 0);
    run_case(8, 16'h0131, 8, 0);
    run_case(0, 16'h0001, 5, 1);

    // random mix of lengths, taps, counts and pause modes
    for (int it = 0; it < 30; it++) begin
      int md, l, nn;
      md = it % 5;
      l = int'($urandom % 16);
      nn = (md == 3) ? depth_for(l) : 1 + int'($urandom % depth_for(l));
      run_case(l, 16'($urandom), nn, md);
    end

    // R6 write while full wraps to empty, no irq, no shifting
    len = 3;
    cfg_len = 4'(len);
    cfg_taps = 16'h0009;
    do_clear();
    for (int k = 0; k < 16; k++) push_word(16'($urandom));
    chk(full == 1'b1, "R2 full at 16 words", full, 1);
    push_word(16'h0005);
    chk(cnt == 5'd0 && empty && !full, "R6 wrap to empty", cnt, 0);
    chk(irq == 1'b0, "R6 no irq on wrap", irq, 0);
    go = 1'b1;
    bad_irq = 0;
    repeat (6) begin tick(); if (irq) bad_irq++; end
    chk(bad_irq == 0, "R6 no irq after wrap", bad_irq, 0);
    chk(crc_out == 16'd0, "R6 no shifting after wrap", crc_out, 0);
    go = 1'b0;
    w = 16'h000b;
    push_word(w);
    e = ref_word(16'd0, len, 16'h0009, w);
    go = 1'b1;
    repeat (len + 1) tick();
    chk(crc_out == e, "R6 fresh word after wrap", crc_out, e);
    chk(irq == 1'b1, "R7 irq after single word", irq, 1);
    go = 1'b0;

    // R3 simultaneous write and retire
    len = 5;
    cfg_len = 4'(len);
    cfg_taps = 16'h0023;
    do_clear();
    e = '0;
    for (int k = 0; k < 2; k++) begin
      w = 16'($urandom);
      e = ref_word(e, len, 16'h0023, w);
      push_word(w);
    end
    go = 1'b1;
    repeat (len) tick();
    w = 16'($urandom);
    e = ref_word(e, len, 16'h0023, w);
    wr_en = 1'b1;
    wr_data = w;
    tick();
    wr_en = 1'b0;
    chk(cnt == 5'd2, "R3 push and retire together", cnt, 2);
    repeat (2 * (len + 1)) tick();
    chk(cnt == 5'd0 && crc_out == e, "R3 stream crc", crc_out, e);
    go = 1'b0;

    // R9 clear mid-word while frozen, then fresh word
    push_word(16'h0f0f);
    push_word(16'h3c3c);
    go = 1'b1;
    repeat (3) tick();
    go = 1'b0;
    sleep = 1'b1;
    do_clear();
    chk(cnt == 5'd0 && crc_out == 16'd0, "R9 clear while frozen", cnt, 0);
    sleep = 1'b0;
    w = 16'h002d;
    push_word(w);
    e = ref_word(16'd0, len, 16'h0023, w);
    go = 1'b1;
    repeat (len + 1) tick();
    chk(crc_out == e, "R9 bit position restarted", crc_out, e);
    go = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule